// File: doc/BRIEF.md
# Asynchronous 16-bit Processor Bus Slave Port

This block lets an external processor with a 16-bit asynchronous bus reach a byte-addressed register space inside a clocked core. The processor presents a chip select, a read strobe, two write-side pins, a low-byte enable and a word address. The word address stands for byte-address bits 8 down to 1. Write data and write-side pins pass through two-stage synchronizers into the core clock. A write is committed once, when the synchronized write strobe is released, as a single-cycle register write with per-byte enables. Reads are combinational: the register address follows the address pins, and the steered read word is driven onto the data bus only during an active read.

A small mode register inside the port selects the byte order (big or little endian) and the write-qualification style. In strobe style, two separate write strobes each write one byte. In byte-enable style, a single write strobe is qualified by a high and a low byte enable. The high write pin and the low write pin are shared by both styles. Software programs the mode register right after reset. The same register also selects how the active-low interrupt pin is driven.

Top module: `cpu_bus_slave`

## Requirements
- R1: The data bus output enable `data_oe_o` is 1 only while `cs_ni` and `rd_ni` are both 0. Otherwise it is 0, so the bus is high-impedance.
- R2: In big-endian mode, a read drives the even byte (`reg_rdata_i[7:0]`) on pin lane `data_o[15:8]` and the odd byte (`reg_rdata_i[15:8]`) on `data_o[7:0]`. `reg_raddr_o` equals `addr_i`.
- R3: In little-endian mode, a read drives the even byte on `data_o[7:0]` and the odd byte on `data_o[15:8]`.
- R4: In strobe style, `wr_hi_ni` low enables pin lane 15:8 and `wr_lo_ni` low enables pin lane 7:0. Either one starts a write. `be_lo_ni` has no effect.
- R5: In byte-enable style, only `wr_lo_ni` is the write strobe. `wr_hi_ni` low enables pin lane 15:8 and `be_lo_ni` low enables pin lane 7:0. A strobe with neither byte enable, or `wr_hi_ni` low without the strobe, writes nothing.
- R6: On the register side, bit 0 of `reg_wbe_o` and `reg_wdata_o[7:0]` are the even byte, and bit 1 and `[15:8]` are the odd byte. Pin lanes map to these bytes by the same endian rule as reads.
- R7: Each write access that enables at least one byte gives exactly one single-cycle `reg_we_o` pulse, after the strobe is released. With `cs_ni` high, no write occurs.
- R8: The mode register sits at word address `MODE_WADDR` (default 0) and resets to 0. It takes pin bits 7:0 whenever pin lane 7:0 is enabled: bit 0 selects little endian, bit 1 selects byte-enable style, bit 2 selects the drive-low-only interrupt. Writes to it are not forwarded to the register side. A read of it returns the mode on `data_o[7:0]` and zeros elsewhere.
- R9: With mode bit 2 clear, the interrupt pin is always driven (`irq_oe_o`=1) and `irq_o` is the inverse of `irq_i`.
- R10: With mode bit 2 set, `irq_o` is 0 and `irq_oe_o` equals `irq_i`, so the pin floats when no interrupt is pending.
- R11: After reset, `reg_we_o` is 0, the bus is not driven, and the mode is big endian, strobe style and push-pull interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_hi_ni | input | 1 | High write strobe (strobe style) or high byte enable (byte-enable style) |
| wr_lo_ni | input | 1 | Low write strobe (strobe style) or the single write strobe |
| be_lo_ni | input | 1 | Low byte enable, byte-enable style only |
| addr_i | input | 8 | Word address, byte-address bits 8:1 |
| data_i | input | 16 | Data bus input |
| data_o | output | 16 | Data bus read value |
| data_oe_o | output | 1 | Data bus output enable |
| reg_raddr_o | output | 8 | Register read word address |
| reg_rdata_i | input | 16 | Register read word, even byte in [7:0] |
| reg_we_o | output | 1 | Register write pulse |
| reg_waddr_o | output | 8 | Register write word address |
| reg_wdata_o | output | 16 | Register write word, even byte in [7:0] |
| reg_wbe_o | output | 2 | Register byte enables, bit 0 even byte |
| irq_i | input | 1 | Internal interrupt request, active high |
| irq_o | output | 1 | Interrupt pin value, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
A wrong endian or style bit in the mode register shows at once on the next read as swapped lanes on `data_o`. It also shows on the next write, a few cycles after strobe release, as swapped or missing byte enables. A stuck or repeated activity flag in the capture logic shows as a missing or doubled `reg_we_o` pulse. The scoreboard catches this when the expected queue is not exactly empty after each access. A write that leaks into the mode register, or a mode write that leaks out, shows as an unexpected register write or as changed steering on the following access.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef struct packed {
    logic irq_od;   // bit 2
    logic be_style; // bit 1
    logic little;   // bit 0
  } mode_t;
  localparam int MODE_W = 3;
endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cbs_lane_map.sv
module cbs_lane_map #(
  parameter int DW = 16
) (
  input  logic          little_i,
  input  logic [DW-1:0] pin_wdata_i,
  input  logic [1:0]    pin_lanes_i,   // [1] pin lane high, [0] pin lane low
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] reg_wdata_o,
  output logic [1:0]    reg_wbe_o,     // [0] even byte, [1] odd byte
  output logic [DW-1:0] pin_rdata_o
);
  localparam int BW = DW / 2;

  // big endian: even byte rides the high pin lane
  always_comb begin
    if (little_i) begin
      reg_wdata_o = pin_wdata_i;
      reg_wbe_o   = pin_lanes_i;
      pin_rdata_o = reg_rdata_i;
    end else begin
      reg_wdata_o = {pin_wdata_i[BW-1:0], pin_wdata_i[DW-1:BW]};
      reg_wbe_o   = {pin_lanes_i[0], pin_lanes_i[1]};
      pin_rdata_o = {reg_rdata_i[BW-1:0], reg_rdata_i[DW-1:BW]};
    end
  end
endmodule

// File: rtl/cbs_write_capture.sv
module cbs_write_capture #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          be_style_i,
  input  logic          cs_n_i,
  input  logic          wr_hi_n_i,
  input  logic          wr_lo_n_i,
  input  logic          be_lo_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] cap_data_o,
  output logic [1:0]    cap_lanes_o
);
  logic       act, act_q;
  logic [1:0] lanes_now;

  always_comb begin
    if (be_style_i) begin
      act       = !cs_n_i && !wr_lo_n_i;
      lanes_now = {!wr_hi_n_i, !be_lo_n_i};
    end else begin
      act       = !cs_n_i && (!wr_hi_n_i || !wr_lo_n_i);
      lanes_now = {!wr_hi_n_i, !wr_lo_n_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      cap_addr_o  <= '0;
      cap_data_o  <= '0;
      cap_lanes_o <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        cap_addr_o  <= addr_i;
        cap_data_o  <= data_i;
        cap_lanes_o <= (act_q ? cap_lanes_o : 2'b00) | lanes_now;
      end
    end
  end

  // commit on release of the strobe, only if some byte was enabled
  assign commit_o = act_q && !act && (cap_lanes_o != 2'b00);

  a_r7_one_commit_per_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/cbs_irq_drive.sv
module cbs_irq_drive (
  input  logic irq_i,
  input  logic od_i,
  output logic irq_o,
  output logic irq_oe_o
);
  always_comb begin
    if (od_i) begin
      irq_o    = 1'b0;
      irq_oe_o = irq_i;
    end else begin
      irq_o    = !irq_i;
      irq_oe_o = 1'b1;
    end
  end

  always_comb begin
    if (od_i) a_r10_never_drive_high: assert (!(irq_oe_o && irq_o));
  end
endmodule

// File: rtl/cpu_bus_slave.sv
module cpu_bus_slave #(
  parameter int          DW         = 16,
  parameter int          AW         = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MODE_WADDR = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_hi_ni,
  input  logic          wr_lo_ni,
  input  logic          be_lo_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [AW-1:0] reg_raddr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [1:0]    reg_wbe_o,
  input  logic          irq_i,
  output logic          irq_o,
  output logic          irq_oe_o
);
  import cbs_pkg::*;

  localparam int CTRL_W = 4;
  localparam int BUS_W  = AW + DW;
  localparam logic [AW-1:0] MODE_A = AW'(MODE_WADDR);

  mode_t mode_q;

  logic [CTRL_W-1:0] ctrl_s;
  logic [BUS_W-1:0]  bus_s;

  cbs_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_hi_ni, wr_lo_ni, be_lo_ni}),
    .q_o   (ctrl_s)
  );

  // address/data delayed alongside the strobes so capture sees matching samples
  cbs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_s)
  );

  logic          commit;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic [1:0]    cap_lanes;

  cbs_write_capture #(.DW(DW), .AW(AW)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .be_style_i (mode_q.be_style),
    .cs_n_i     (ctrl_s[3]),
    .wr_hi_n_i  (ctrl_s[2]),
    .wr_lo_n_i  (ctrl_s[1]),
    .be_lo_n_i  (ctrl_s[0]),
    .addr_i     (bus_s[BUS_W-1:DW]),
    .data_i     (bus_s[DW-1:0]),
    .commit_o   (commit),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data),
    .cap_lanes_o(cap_lanes)
  );

  logic [DW-1:0] map_wdata, map_rdata;
  logic [1:0]    map_wbe;

  cbs_lane_map #(.DW(DW)) u_lane_map (
    .little_i   (mode_q.little),
    .pin_wdata_i(cap_data),
    .pin_lanes_i(cap_lanes),
    .reg_rdata_i(reg_rdata_i),
    .reg_wdata_o(map_wdata),
    .reg_wbe_o  (map_wbe),
    .pin_rdata_o(map_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      reg_we_o    <= 1'b0;
      reg_waddr_o <= '0;
      reg_wdata_o <= '0;
      reg_wbe_o   <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (commit) begin
        if (cap_addr == MODE_A) begin
          if (cap_lanes[0]) mode_q <= mode_t'(cap_data[MODE_W-1:0]);
        end else begin
          reg_we_o    <= 1'b1;
          reg_waddr_o <= cap_addr;
          reg_wdata_o <= map_wdata;
          reg_wbe_o   <= map_wbe;
        end
      end
    end
  end

  assign reg_raddr_o = addr_i;
  assign data_oe_o   = !cs_ni && !rd_ni;
  assign data_o      = (addr_i == MODE_A) ? {{(DW-MODE_W){1'b0}}, mode_q} : map_rdata;

  cbs_irq_drive u_irq (
    .irq_i   (irq_i),
    .od_i    (mode_q.irq_od),
    .irq_o   (irq_o),
    .irq_oe_o(irq_oe_o)
  );

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r8_mode_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(mode_q));
  a_r8_mode_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_waddr_o != MODE_A);
  a_r6_write_has_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_wbe_o != 2'b00);
endmodule

// File: tb/cpu_bus_slave_bench.sv
module cpu_bus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, wr_hi_ni = 1'b1, wr_lo_ni = 1'b1, be_lo_ni = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;
  logic [7:0]  reg_raddr_o;
  logic [15:0] reg_rdata_i = '0;
  logic        reg_we_o;
  logic [7:0]  reg_waddr_o;
  logic [15:0] reg_wdata_o;
  logic [1:0]  reg_wbe_o;
  logic        irq_i = 1'b0;
  logic        irq_o, irq_oe_o;

  always #2 clk = ~clk;

  cpu_bus_slave u_cpu_bus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .wr_hi_ni(wr_hi_ni), .wr_lo_ni(wr_lo_ni), .be_lo_ni(be_lo_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .reg_raddr_o(reg_raddr_o), .reg_rdata_i(reg_rdata_i),
    .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o),
    .reg_wbe_o(reg_wbe_o), .irq_i(irq_i), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  typedef struct { logic [7:0] a; logic [1:0] be; logic [15:0] d; } exp_t;
  exp_t exp_q[$];

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  cur_little = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: every register write must match the head of the queue
  always @(negedge clk) begin
    if (rst_ni && reg_we_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected write", {24'h0, reg_waddr_o}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        logic [15:0] m;
        e = exp_q.pop_front();
        m = {{8{e.be[1]}}, {8{e.be[0]}}};
        chk(reg_waddr_o == e.a, "R6 addr", {24'h0, reg_waddr_o}, {24'h0, e.a});
        chk(reg_wbe_o == e.be, "R6 byte enables", {30'h0, reg_wbe_o}, {30'h0, e.be});
        chk((reg_wdata_o & m) == (e.d & m), "R6 data", {16'h0, reg_wdata_o & m}, {16'h0, e.d & m});
      end
    end
  end

  // hi/lo: pin lanes enabled; bem: byte-enable style; noise: be_lo pin level in strobe style
  task automatic do_wr(logic [7:0] a, logic [15:0] d, bit hi, bit lo, bit bem, bit noise, string req);
    exp_t e;
    if ((hi || lo) && a != 8'h00) begin
      e.a  = a;
      e.be = cur_little ? {hi, lo} : {lo, hi};
      e.d  = cur_little ? d : {d[7:0], d[15:8]};
      exp_q.push_back(e);
    end
    @(negedge clk);
    cs_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk);
    if (bem) begin
      wr_lo_ni = 1'b0; wr_hi_ni = !hi; be_lo_ni = !lo;
    end else begin
      wr_hi_ni = !hi; wr_lo_ni = !lo; be_lo_ni = noise;
    end
    repeat (4) @(negedge clk);
    wr_hi_ni = 1'b1; wr_lo_ni = 1'b1; be_lo_ni = 1'b1;
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk);
    cs_ni = 1'b0; addr_i = 8'h00; data_i = {8'hEE, 5'h0, m};
    @(negedge clk);
    wr_lo_ni = 1'b0; be_lo_ni = 1'b0;
    repeat (4) @(negedge clk);
    wr_lo_ni = 1'b1; be_lo_ni = 1'b1;
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
    cur_little = m[0];
    chk(exp_q.size() == 0, "R8 not forwarded", exp_q.size(), 0);
  endtask

  task automatic do_rd(logic [7:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b0; addr_i = a;
    #1;
    chk(data_oe_o == 1'b1, "R1 driven during read", data_oe_o, 1);
    chk(reg_raddr_o == a, "R2 read address", reg_raddr_o, a);
    chk(data_o == exp, req, data_o, exp);
    @(negedge clk);
    rd_ni = 1'b1; cs_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(data_oe_o == 1'b0, "R11 bus idle", data_oe_o, 0);
    chk(reg_we_o == 1'b0, "R11 no write", reg_we_o, 0);
    chk(irq_oe_o == 1'b1 && irq_o == 1'b1, "R9 push-pull idle", {irq_oe_o, irq_o}, 2'b11);
    do_rd(8'h00, 16'h0000, "R11 mode reset value");

    // R1 partial selects
    cs_ni = 1'b1; rd_ni = 1'b0; #1;
    chk(data_oe_o == 1'b0, "R1 no cs", data_oe_o, 0);
    cs_ni = 1'b0; rd_ni = 1'b1; #1;
    chk(data_oe_o == 1'b0, "R1 no rd", data_oe_o, 0);
    cs_ni = 1'b1;

    // R2 big endian read
    reg_rdata_i = 16'h12AB;
    do_rd(8'h05, 16'hAB12, "R2 big endian read");

    // R4 strobe style writes, big endian
    do_wr(8'h03, 16'hC3A5, 1, 1, 0, 1, "R4 both strobes");
    do_wr(8'h04, 16'h5A00, 1, 0, 0, 0, "R4 high strobe, be_lo ignored");
    do_wr(8'h07, 16'h0077, 0, 1, 0, 1, "R4 low strobe");

    // R7 strobe without chip select
    @(negedge clk);
    addr_i = 8'h09; wr_lo_ni = 1'b0; wr_hi_ni = 1'b0;
    repeat (4) @(negedge clk);
    wr_lo_ni = 1'b1; wr_hi_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 no cs no write", exp_q.size(), 0);

    // R8 little endian
    set_mode(3'b001);
    do_rd(8'h00, 16'h0001, "R8 mode readback");
    do_rd(8'h05, 16'h12AB, "R3 little endian read");
    do_wr(8'h10, 16'hBEEF, 1, 0, 0, 0, "R6 little high lane");
    do_wr(8'h11, 16'h1234, 1, 1, 0, 1, "R6 little both lanes");

    // R5 byte-enable style, little endian
    set_mode(3'b011);
    do_wr(8'h20, 16'hCAFE, 1, 1, 1, 0, "R5 both enables");
    do_wr(8'h21, 16'h00D1, 0, 1, 1, 0, "R5 low enable");
    do_wr(8'h22, 16'h9900, 0, 0, 1, 0, "R5 no enable writes nothing");
    // high pin alone is not a strobe in byte-enable style
    @(negedge clk);
    cs_ni = 1'b0; addr_i = 8'h23; data_i = 16'hFFFF;
    @(negedge clk); wr_hi_ni = 1'b0;
    repeat (4) @(negedge clk); wr_hi_ni = 1'b1;
    repeat (4) @(negedge clk); cs_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 high pin alone no write", exp_q.size(), 0);

    // R10 drive-low-only interrupt, byte-enable style, big endian
    set_mode(3'b110);
    irq_i = 1'b0; #1;
    chk(irq_oe_o == 1'b0, "R10 float when idle", irq_oe_o, 0);
    irq_i = 1'b1; #1;
    chk(irq_oe_o == 1'b1 && irq_o == 1'b0, "R10 drive low", {irq_oe_o, irq_o}, 2'b10);
    do_wr(8'h30, 16'h4321, 1, 0, 1, 0, "R5 big endian high enable");

    // R9 back to push-pull
    set_mode(3'b000);
    irq_i = 1'b1; #1;
    chk(irq_oe_o == 1'b1 && irq_o == 1'b0, "R9 asserted", {irq_oe_o, irq_o}, 2'b10);
    irq_i = 1'b0; #1;
    chk(irq_oe_o == 1'b1 && irq_o == 1'b1, "R9 released", {irq_oe_o, irq_o}, 2'b11);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 run did not complete actual=1 expected=0");
      summary();
      $finish;
    end
  end
endmodule